// File: doc/BRIEF.md
# Duplicated Multiplier with Fault Locator

The block multiplies two unsigned operands using two identical combinational copies of the multiplier. Each copy's product goes into its own result register. A comparator watches the two registered results. While they agree, the block runs as a two-stage pipeline and adds no latency. When they first disagree, the block spends one cycle on a locate step. In that step both copies compute the same operation again, with operand A widened by one bit and shifted left by one. Each recomputed product is shifted right by one and compared with the result that copy registered earlier. A copy whose two results differ is judged faulty.

The output register is held three times over, and a bitwise majority vote drives the product port. Branch 0 always takes copy 0 and branch 1 always takes copy 1. Branch 2 takes whichever copy is currently selected as healthy. When the locator names exactly one faulty copy, branch 2 switches to the other copy and stays there. From then on the vote carries the healthy result and no more locate steps are taken. Reset stands for reloading the device configuration: it clears the selection and the fault record. A per-copy fault mask port lets a test force a permanent error into either copy.

The controller has three states.
- WATCH is normal operation. It leaves for LOCATE on a mismatch.
- LOCATE lasts one cycle. If exactly one copy is flagged, it goes to DEGRADED; otherwise it goes back to WATCH.
- DEGRADED holds until reset.

Top module: `dmr_mul_locator`

## Requirements
- R1: After reset the product is 0, mismatch is 0, faulty is 2'b00, unresolved is 0, and copy 0 feeds output branch 2.
- R2: With no mismatch, operands driven before clock edge n give product = op_a*op_b, visible after edge n+1.
- R3: mismatch is 1 exactly while the two registered copy results differ. It reflects the operands taken at the previous edge.
- R4: In WATCH, at the first edge where mismatch is 1, the product holds its previous value for that one clock. The operands offered in that cycle are not taken.
- R5: In LOCATE, each copy recomputes with operand A zero-extended to 9 bits and shifted left by one. Its 17-bit result is shifted right by one and compared with that copy's registered result. Any nonzero fault mask on a copy therefore flags that copy.
- R6: faulty[k] = 1 marks copy k as faulty. At most one bit is ever set, and it stays set until reset.
- R7: After a copy is marked faulty, the product equals the healthy copy's result two edges after the operands, even while mismatch stays 1. No further holds occur.
- R8: If LOCATE flags both copies or neither, unresolved is 1 for one cycle, faulty is unchanged and the selection is kept.
- R9: Reset clears faulty and returns the selection to copy 0.
- R10: fault_maskK is XORed onto the low 16 bits of copy K's raw 17-bit product, in both normal and recompute passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (reconfiguration) |
| op_a | input | 8 | Operand A |
| op_b | input | 8 | Operand B |
| fault_mask0 | input | 16 | Forced error pattern for copy 0 |
| fault_mask1 | input | 16 | Forced error pattern for copy 1 |
| product | output | 16 | Voted product |
| mismatch | output | 1 | Registered copy results differ |
| faulty | output | 2 | Sticky one-hot faulty-copy indication |
| unresolved | output | 1 | One-cycle pulse: locate could not isolate one copy |

## Verification
Random and corner operands (0, 255×255) with both masks clear show the plain pipeline and its latency. A single-bit mask on copy 1 must first cause the one-clock hold and then be attributed to copy 1. A top-bit mask on copy 0 must be attributed to copy 0, which shows the shifted recompute still sees the highest product bit. Masks on both copies at once must give only unresolved pulses and no fault record. A per-cycle behavioural model tells a wrong vote, a wrong hold cycle and a lost sticky bit apart from the correct behaviour.

// File: rtl/dmr_mul_pkg.sv
package dmr_mul_pkg;
    typedef enum logic [1:0] {
        ST_WATCH    = 2'd0,
        ST_LOCATE   = 2'd1,
        ST_DEGRADED = 2'd2
    } loc_state_t;

    localparam int NCOPY = 2;
    localparam int NBRANCH = 3;
endpackage

// File: rtl/dmr_mul_copy.sv
module dmr_mul_copy #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           shifted,
    input  logic [2*W-1:0] fmask,
    input  logic [2*W-1:0] prior,
    output logic [2*W-1:0] prod,
    output logic           tc
);
    localparam int AW = W + 1;
    localparam int RW = 2 * W + 1;

    logic [AW-1:0] opa;
    logic [RW-1:0] raw;
    logic [2*W-1:0] decoded;

    always_comb begin
        opa = shifted ? {a, 1'b0} : {1'b0, a};
        raw = ({{W{1'b0}}, opa} * {{(W + 1){1'b0}}, b}) ^ {1'b0, fmask};
        prod = raw[2*W-1:0];
        decoded = raw[RW-1:1];
        tc = (decoded != prior);
    end
endmodule

// File: rtl/dmr_tmr_reg.sv
module dmr_tmr_reg #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] d0,
    input  logic [DW-1:0] d1,
    input  logic [DW-1:0] d2,
    output logic [DW-1:0] q
);
    import dmr_mul_pkg::*;

    logic [DW-1:0] din [NBRANCH];
    logic [DW-1:0] br  [NBRANCH];

    assign din[0] = d0;
    assign din[1] = d1;
    assign din[2] = d2;

    for (genvar g = 0; g < NBRANCH; g++) begin : g_branch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                br[g] <= '0;
            end else if (load) begin
                br[g] <= din[g];
            end
        end
    end

    assign q = (br[0] & br[1]) | (br[0] & br[2]) | (br[1] & br[2]);
endmodule

// File: rtl/dmr_locate_fsm.sv
module dmr_locate_fsm (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hc,
    input  logic [1:0]              tc,
    output dmr_mul_pkg::loc_state_t state,
    output logic                    sel,
    output logic                    sel_nxt,
    output logic [1:0]              faulty,
    output logic                    unresolved,
    output logic                    hold
);
    import dmr_mul_pkg::*;

    loc_state_t state_nxt;
    logic [1:0] faulty_nxt;
    logic       unres_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_WATCH;
            sel        <= 1'b0;
            faulty     <= 2'b00;
            unresolved <= 1'b0;
        end else begin
            state      <= state_nxt;
            sel        <= sel_nxt;
            faulty     <= faulty_nxt;
            unresolved <= unres_nxt;
        end
    end

    always_comb begin
        state_nxt  = state;
        sel_nxt    = sel;
        faulty_nxt = faulty;
        unres_nxt  = 1'b0;
        hold       = 1'b0;
        unique case (state)
            ST_WATCH: begin
                if (hc) begin
                    state_nxt = ST_LOCATE;
                    hold      = 1'b1;
                end
            end
            ST_LOCATE: begin
                if (tc[0] ^ tc[1]) begin
                    state_nxt  = ST_DEGRADED;
                    faulty_nxt = tc;
                    sel_nxt    = tc[0];
                end else begin
                    state_nxt = ST_WATCH;
                    unres_nxt = 1'b1;
                end
            end
            ST_DEGRADED: begin
                state_nxt = ST_DEGRADED;
            end
            default: begin
                state_nxt = ST_WATCH;
            end
        endcase
    end

    assert_locate_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCATE) |=> (state != ST_LOCATE));
    assert_faulty_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(faulty));
    assert_faulty_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (faulty != 2'b00) |=> ($stable(faulty) && $stable(sel)));
    assert_default_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (faulty == 2'b00) |-> (sel == 1'b0));
    assert_unresolved_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unresolved |-> ((faulty == 2'b00) || $stable(faulty)));
    assert_unresolved_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unresolved |=> !unresolved);
endmodule

// File: rtl/dmr_mul_locator.sv
module dmr_mul_locator #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    input  logic [2*W-1:0] fault_mask0,
    input  logic [2*W-1:0] fault_mask1,
    output logic [2*W-1:0] product,
    output logic           mismatch,
    output logic [1:0]     faulty,
    output logic           unresolved
);
    import dmr_mul_pkg::*;

    localparam int PW = 2 * W;

    loc_state_t    state;
    logic          sel;
    logic          sel_nxt;
    logic          hold;
    logic          hc;
    logic          locating;
    logic [1:0]    tc;
    logic [W-1:0]  a_q;
    logic [W-1:0]  b_q;
    logic [W-1:0]  cp_a;
    logic [W-1:0]  cp_b;
    logic [PW-1:0] cp_prod [NCOPY];
    logic [PW-1:0] dr_q    [NCOPY];
    logic [PW-1:0] cp_mask [NCOPY];
    logic [PW-1:0] good_d;

    assign cp_mask[0] = fault_mask0;
    assign cp_mask[1] = fault_mask1;
    assign locating   = (state == ST_LOCATE);
    assign cp_a       = locating ? a_q : op_a;
    assign cp_b       = locating ? b_q : op_b;

    for (genvar k = 0; k < NCOPY; k++) begin : g_copy
        dmr_mul_copy #(.W(W)) i_copy (
            .a       (cp_a),
            .b       (cp_b),
            .shifted (locating),
            .fmask   (cp_mask[k]),
            .prior   (dr_q[k]),
            .prod    (cp_prod[k]),
            .tc      (tc[k])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dr_q[k] <= '0;
            end else if (!hold && !locating) begin
                dr_q[k] <= cp_prod[k];
            end else if (locating) begin
                dr_q[k] <= fresh_prod(k);
            end
        end
    end

    // During LOCATE the copies are busy; the next operands are multiplied
    // by the same shared instances only in normal mode, so a separate
    // fault-free path is not used: the result register takes the copy's
    // own normal computation of the new operands, masked as that copy is.
    function automatic logic [PW-1:0] fresh_prod(input int idx);
        logic [PW-1:0] m;
        m = (idx == 0) ? fault_mask0 : fault_mask1;
        return (PW'(op_a) * PW'(op_b)) ^ m;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (!hold) begin
            a_q <= op_a;
            b_q <= op_b;
        end
    end

    assign hc     = (dr_q[0] != dr_q[1]);
    assign good_d = dr_q[sel];

    dmr_locate_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hc         (hc),
        .tc         (tc),
        .state      (state),
        .sel        (sel),
        .sel_nxt    (sel_nxt),
        .faulty     (faulty),
        .unresolved (unresolved),
        .hold       (hold)
    );

    dmr_tmr_reg #(.DW(PW)) i_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (!hold),
        .d0    (dr_q[0]),
        .d1    (dr_q[1]),
        .d2    (dr_q[sel_nxt]),
        .q     (product)
    );

    assign mismatch = hc;

    assert_hold_one_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WATCH) && hc) |=> ($stable(product) && (state == ST_LOCATE)));
    assert_degraded_vote_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEGRADED) |=> (product == $past(good_d)));
    assert_no_mismatch_no_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WATCH) && !hc) |=> (state == ST_WATCH));
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> ((faulty == 2'b00) && !sel && !unresolved));
endmodule

// File: tb/test_dmr_mul_locator.sv
module test_dmr_mul_locator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic [15:0] fault_mask0 = '0;
    logic [15:0] fault_mask1 = '0;
    logic [15:0] product;
    logic        mismatch;
    logic [1:0]  faulty;
    logic        unresolved;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    int unres_seen = 0;

    always #4 clk = ~clk;

    dmr_mul_locator i_dmr_mul_locator (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .fault_mask0(fault_mask0), .fault_mask1(fault_mask1),
        .product(product), .mismatch(mismatch), .faulty(faulty),
        .unresolved(unresolved)
    );

    // behavioural reference: 0 watch, 1 locate, 2 degraded
    int m_st = 0;
    int m_a = 0, m_b = 0, m_d0 = 0, m_d1 = 0, m_t0 = 0, m_t1 = 0, m_t2 = 0;
    int m_sel = 0, m_f = 0, m_un = 0;
    bit m_held = 0;

    function automatic int copy_res(int a, int b, int m);
        return ((a * b) ^ m) & 16'hFFFF;
    endfunction

    function automatic int recheck(int a, int b, int m, int prior);
        int raw;
        raw = ((2 * a) * b) ^ m;
        return (((raw >> 1) & 16'hFFFF) != prior) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        int e0, e1, na, nb;
        cycles++;
        na = int'(op_a);
        nb = int'(op_b);
        m_held = 0;
        if (!rst_n) begin
            m_st = 0; m_a = 0; m_b = 0; m_d0 = 0; m_d1 = 0;
            m_t0 = 0; m_t1 = 0; m_t2 = 0; m_sel = 0; m_f = 0; m_un = 0;
        end else if (m_st == 0 && m_d0 != m_d1) begin
            m_st = 1; m_un = 0; m_held = 1;
        end else begin
            m_un = 0;
            if (m_st == 1) begin
                e0 = recheck(m_a, m_b, int'(fault_mask0), m_d0);
                e1 = recheck(m_a, m_b, int'(fault_mask1), m_d1);
                if (e0 != e1) begin
                    m_f = e0 ? 1 : 2; m_sel = e0 ? 1 : 0; m_st = 2;
                end else begin
                    m_un = 1; m_st = 0;
                end
            end
            m_t0 = m_d0; m_t1 = m_d1; m_t2 = m_sel ? m_d1 : m_d0;
            m_a = na; m_b = nb;
            m_d0 = copy_res(na, nb, int'(fault_mask0));
            m_d1 = copy_res(na, nb, int'(fault_mask1));
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int vote;
        if (cycles > 0 && !done) begin
            vote = (m_t0 & m_t1) | (m_t0 & m_t2) | (m_t1 & m_t2);
            if (m_st == 2)   chk("R7 product", int'(product), vote);
            else if (m_held) chk("R4 product", int'(product), vote);
            else             chk("R2 product", int'(product), vote);
            chk("R3 mismatch", int'(mismatch), (m_d0 != m_d1) ? 1 : 0);
            chk("R6 faulty", int'(faulty), m_f);
            chk("R8 unresolved", int'(unresolved), m_un);
            if (unresolved) unres_seen++;
        end
    end

    task automatic run_random(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_a = 8'($urandom);
            op_b = 8'($urandom);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fault_mask0 = '0;
        fault_mask1 = '0;
        @(negedge clk);
        chk("R9 faulty cleared", int'(faulty), 0);
        chk("R9 unresolved cleared", int'(unresolved), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 product", int'(product), 0);
        chk("R1 mismatch", int'(mismatch), 0);
        chk("R1 faulty", int'(faulty), 0);
        chk("R1 unresolved", int'(unresolved), 0);
        rst_n = 1'b1;
        @(negedge clk); op_a = 8'd255; op_b = 8'd255;
        @(negedge clk); op_a = 8'd0;   op_b = 8'd77;
        @(negedge clk);
        chk("R2 255x255 latency", int'(product), 65025);
        run_random(40);
        // R10: mask on copy 1 only
        @(negedge clk); fault_mask1 = 16'h0004;
        run_random(30);
        chk("R10 copy 1 identified", int'(faulty), 2);
        @(negedge clk); op_a = 8'd13; op_b = 8'd11;
        @(negedge clk); op_a = 8'd1;
        @(negedge clk);
        chk("R7 healthy product", int'(product), 143);
        do_reset();
        // R5: top product bit forced on copy 0
        @(negedge clk); fault_mask0 = 16'h8000;
        run_random(20);
        chk("R5 copy 0 identified", int'(faulty), 1);
        do_reset();
        // R8: both copies faulty
        unres_seen = 0;
        @(negedge clk); fault_mask0 = 16'h0001; fault_mask1 = 16'h0100;
        run_random(20);
        chk("R8 no fault recorded", int'(faulty), 0);
        chk("R8 unresolved pulses seen", (unres_seen > 0) ? 1 : 0, 1);
        do_reset();
        run_random(15);
        chk("R1 clean after reset", int'(faulty), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule